// File: doc/BRIEF.md
# Read/Write Bus Turnaround Scheduler

This block chooses, separately for each memory pseudo channel, whether the next data burst on that channel's data bus is a read or a write. Each channel watches its own read-queue and write-queue occupancy, a controller-wide drain request, and two saturating counters. One counts the reads issued since the channel last turned the bus around. The other counts the writes issued since then. The queues themselves, DRAM timing and bank choice live elsewhere. The block only holds and updates the direction.

Switching is governed by two write watermarks and by a minimum number of bursts per direction. The high watermark is the buffer depth times a high percentage divided by 100. The low watermark is worked out the same way from a low percentage. Each channel has a pending next direction, which is computed at every scheduling step. The current direction takes that value at the following step, and a one-cycle turnaround pulse is raised when the two differ. The channels are replicated by a generate loop and share no state, so two channels can face opposite directions at once.

Top module: `rw_turn_sched`

## Requirements
- R1: Out of reset, and after any synchronous reset, every channel reports current direction READ and next direction READ (direction bit 0 = READ, 1 = WRITE), with the turnaround pulse low.
- R2: In READ with the channel's read occupancy zero, the next direction becomes WRITE only when write occupancy is non-zero and either drain is requested or write occupancy is strictly above the low watermark.
- R3: In READ with read occupancy non-zero, the next direction becomes WRITE only when write occupancy is strictly above the high watermark and the read count of this turn has reached the minimum reads per switch.
- R4: In WRITE, the next direction returns to READ when write occupancy is zero, or when write occupancy plus the minimum writes per switch is below the low watermark with no drain request, or when read occupancy is non-zero and the write count of this turn has reached the minimum writes per switch. Otherwise it stays WRITE.
- R5: The high and low watermarks are the buffer depth times the respective percentage, divided by 100 and rounded down. Elaboration fails if the low watermark is above the high one.
- R6: A step with the burst flag set adds one to the count of the direction in force for that step. A READ to WRITE turnaround clears the read count, and a WRITE to READ turnaround clears the write count.
- R7: At each step the current direction takes the pending next direction. The turnaround output is high for exactly the one cycle after a step at which they differed. Without a step, neither direction changes.
- R8: Each channel decides only from its own inputs. A channel that is not stepped keeps its direction while another channel switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drain_i | input | 1 | Drain request, shared by all channels |
| step_i | input | NUM_CH | Scheduling step strobe, one bit per channel |
| burst_i | input | NUM_CH | A burst issued at this step in the direction in force |
| rd_occ_i | input | NUM_CH*OCC_W | Read-queue occupancy per channel, after this step's issue |
| wr_occ_i | input | NUM_CH*OCC_W | Write-queue occupancy per channel, after this step's issue |
| cur_dir_o | output | NUM_CH | Current direction per channel (1 = WRITE) |
| nxt_dir_o | output | NUM_CH | Pending next direction per channel (1 = WRITE) |
| turn_o | output | NUM_CH | One-cycle turnaround pulse per channel |

## Verification
The bench builds two channels with a buffer depth of 20, a 60 % high and a 30 % low percentage, which give watermarks of 12 and 6. It sets three reads and two writes as the per-direction minimums. With these small values, a few steps are enough to reach both sides of each watermark, the exact-threshold cases where no switch may happen, and the drain override in both directions. The bench can also show that a cleared read count delays the next switch by one extra burst. A second channel is held idle and then switched alone to show the channels stay separate.

// File: rtl/rw_turn_pkg.sv
// Shared types for the read/write turnaround scheduler.
// Assumes: direction is a single bit, 0 for reads and 1 for writes.
package rw_turn_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // Watermark from a depth and a percentage, rounded down.
    function automatic int unsigned pct_of(input int unsigned depth, input int unsigned pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/rw_burst_count.sv
// Saturating per-direction burst counter.
// Assumes: clr_i and inc_i are never high together (the caller clears only the
// direction being left, and counts only the direction being entered).
module rw_burst_count #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Next count: clear wins, otherwise add one and hold at the top value.
    always_comb begin
        cnt_nxt_o = cnt_q;
        if (clr_i)
            cnt_nxt_o = '0;
        else if (inc_i && (cnt_q != CNT_MAX))
            cnt_nxt_o = cnt_q + 1'b1;
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nxt_o;
    end

    assign cnt_o = cnt_q;

    // A turnaround clear must leave the counter at zero.
    assert_cnt_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/rw_dir_decide.sv
// Combinational direction decision for one channel.
// Assumes: occupancies are already reduced by any burst issued at this step,
// and counts already include it.
module rw_dir_decide
    import rw_turn_pkg::*;
#(
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned HI_WM  = 16,
    parameter int unsigned LO_WM  = 8,
    parameter int unsigned MIN_RD = 4,
    parameter int unsigned MIN_WR = 4
) (
    input  dir_e             dir_i,
    input  logic [OCC_W-1:0] rd_occ_i,
    input  logic [OCC_W-1:0] wr_occ_i,
    input  logic             drain_i,
    input  logic [CNT_W-1:0] rd_cnt_i,
    input  logic [CNT_W-1:0] wr_cnt_i,
    output dir_e             dir_o
);
    logic [31:0] rd_n, wr_n, rc_n, wc_n;
    logic        leave;

    // Widen everything to 32 bits so the watermark sums cannot wrap.
    always_comb begin
        rd_n = 32'(rd_occ_i);
        wr_n = 32'(wr_occ_i);
        rc_n = 32'(rd_cnt_i);
        wc_n = 32'(wr_cnt_i);
    end

    // Decide whether the direction in force should be left.
    always_comb begin
        leave = 1'b0;
        if (dir_i == DIR_RD) begin
            if (rd_n == 0)
                leave = (wr_n != 0) && (drain_i || (wr_n > LO_WM));
            else
                leave = (wr_n > HI_WM) && (rc_n >= MIN_RD);
        end else begin
            leave = (wr_n == 0)
                 || (((wr_n + MIN_WR) < LO_WM) && !drain_i)
                 || ((rd_n != 0) && (wc_n >= MIN_WR));
        end
        dir_o = leave ? ((dir_i == DIR_RD) ? DIR_WR : DIR_RD) : dir_i;
    end

endmodule

// File: rtl/rw_chan_sched.sv
// Direction state for one pseudo channel.
// Assumes: a step is one scheduling opportunity; the pending next direction is
// applied at the step and a fresh one is computed from that step's inputs.
module rw_chan_sched
    import rw_turn_pkg::*;
#(
    parameter int unsigned OCC_W  = 6,
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned HI_WM  = 16,
    parameter int unsigned LO_WM  = 8,
    parameter int unsigned MIN_RD = 4,
    parameter int unsigned MIN_WR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             burst_i,
    input  logic             drain_i,
    input  logic [OCC_W-1:0] rd_occ_i,
    input  logic [OCC_W-1:0] wr_occ_i,
    output logic             cur_wr_o,
    output logic             nxt_wr_o,
    output logic             turn_o
);
    dir_e             cur_q, nxt_q, eff, dec;
    logic             turn_q, turn_now;
    logic [CNT_W-1:0] cnt     [2];
    logic [CNT_W-1:0] cnt_nxt [2];

    // The direction in force for this step is the pending one.
    always_comb begin
        eff      = nxt_q;
        turn_now = step_i && (eff != cur_q);
    end

    // One counter per direction: count bursts in that direction, clear when leaving it.
    for (genvar d = 0; d < 2; d++) begin : g_cnt
        logic inc, clr;
        always_comb begin
            inc = step_i && burst_i && (eff == dir_e'(d));
            clr = turn_now && (cur_q == dir_e'(d));
        end
        rw_burst_count #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc),
            .clr_i     (clr),
            .cnt_o     (cnt[d]),
            .cnt_nxt_o (cnt_nxt[d])
        );
    end

    rw_dir_decide #(
        .OCC_W (OCC_W),
        .CNT_W (CNT_W),
        .HI_WM (HI_WM),
        .LO_WM (LO_WM),
        .MIN_RD(MIN_RD),
        .MIN_WR(MIN_WR)
    ) u_decide (
        .dir_i   (eff),
        .rd_occ_i(rd_occ_i),
        .wr_occ_i(wr_occ_i),
        .drain_i (drain_i),
        .rd_cnt_i(cnt_nxt[0]),
        .wr_cnt_i(cnt_nxt[1]),
        .dir_o   (dec)
    );

    // Direction registers and turnaround pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= DIR_RD;
            nxt_q  <= DIR_RD;
            turn_q <= 1'b0;
        end else begin
            turn_q <= turn_now;
            if (step_i) begin
                cur_q <= eff;
                nxt_q <= dec;
            end
        end
    end

    assign cur_wr_o = (cur_q == DIR_WR);
    assign nxt_wr_o = (nxt_q == DIR_WR);
    assign turn_o   = turn_q;

    // Leaving reset both directions are READ.
    assert_reset_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cur_q == DIR_RD && nxt_q == DIR_RD && !turn_q));

    // With no writes queued a READ step can never pick WRITE.
    assert_no_writes_stay_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && nxt_q == DIR_RD && wr_occ_i == '0) |=> (nxt_q == DIR_RD));

    // An empty write queue always sends a WRITE step back to READ.
    assert_empty_writes_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && nxt_q == DIR_WR && wr_occ_i == '0) |=> (nxt_q == DIR_RD));

    // A step moves the pending direction into the current one.
    assert_cur_follows_nxt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (cur_q == $past(nxt_q)));

    // No step, no change.
    assert_hold_without_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(cur_q) && $stable(nxt_q) && !turn_q));

    // A pulse always accompanies a real change of direction.
    assert_turn_is_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        turn_q |-> (cur_q != $past(cur_q)));

endmodule

// File: rtl/rw_turn_sched.sv
// Read/write turnaround scheduler for NUM_CH independent pseudo channels.
// Assumes: occupancy ports are per channel, packed channel 0 in the low bits;
// the drain request applies to all channels alike.
module rw_turn_sched
    import rw_turn_pkg::*;
#(
    parameter int unsigned NUM_CH    = 2,
    parameter int unsigned BUF_DEPTH = 64,
    parameter int unsigned HI_PCT    = 85,
    parameter int unsigned LO_PCT    = 50,
    parameter int unsigned MIN_RD    = 16,
    parameter int unsigned MIN_WR    = 16,
    localparam int unsigned OCC_W    = $clog2(BUF_DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    drain_i,
    input  logic [NUM_CH-1:0]       step_i,
    input  logic [NUM_CH-1:0]       burst_i,
    input  logic [NUM_CH*OCC_W-1:0] rd_occ_i,
    input  logic [NUM_CH*OCC_W-1:0] wr_occ_i,
    output logic [NUM_CH-1:0]       cur_dir_o,
    output logic [NUM_CH-1:0]       nxt_dir_o,
    output logic [NUM_CH-1:0]       turn_o
);
    localparam int unsigned HI_WM   = pct_of(BUF_DEPTH, HI_PCT);
    localparam int unsigned LO_WM   = pct_of(BUF_DEPTH, LO_PCT);
    localparam int unsigned MIN_MAX = (MIN_RD > MIN_WR) ? MIN_RD : MIN_WR;
    localparam int unsigned CNT_W   = (MIN_MAX < 1) ? 1 : $clog2(MIN_MAX + 1);

    // Elaboration guard on the watermark order (R5).
    if (LO_WM > HI_WM) begin : g_bad_wm
        $error("rw_turn_sched: low watermark above high watermark");
    end

    // One independent scheduler per pseudo channel (R8).
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rw_chan_sched #(
            .OCC_W (OCC_W),
            .CNT_W (CNT_W),
            .HI_WM (HI_WM),
            .LO_WM (LO_WM),
            .MIN_RD(MIN_RD),
            .MIN_WR(MIN_WR)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_i  (step_i[c]),
            .burst_i (burst_i[c]),
            .drain_i (drain_i),
            .rd_occ_i(rd_occ_i[c*OCC_W +: OCC_W]),
            .wr_occ_i(wr_occ_i[c*OCC_W +: OCC_W]),
            .cur_wr_o(cur_dir_o[c]),
            .nxt_wr_o(nxt_dir_o[c]),
            .turn_o  (turn_o[c])
        );
    end

endmodule

// File: tb/rw_turn_sched_tb.sv
module rw_turn_sched_tb;
    localparam int NCH   = 2;
    localparam int DEPTH = 20;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int NROW  = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drain = 1'b0;
    logic [NCH-1:0] step = '0, burst = '0;
    logic [NCH*OCC_W-1:0] rd_occ = '0, wr_occ = '0;
    logic [NCH-1:0] cur_dir, nxt_dir, turn;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rw_turn_sched #(
        .NUM_CH(NCH), .BUF_DEPTH(DEPTH), .HI_PCT(60), .LO_PCT(30),
        .MIN_RD(3), .MIN_WR(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .drain_i(drain), .step_i(step), .burst_i(burst),
        .rd_occ_i(rd_occ), .wr_occ_i(wr_occ),
        .cur_dir_o(cur_dir), .nxt_dir_o(nxt_dir), .turn_o(turn)
    );

    // Watermarks: high 12, low 6. Minimum reads 3, minimum writes 2.
    // Columns: step, burst, drain, rd_occ, wr_occ, exp_cur, exp_nxt, exp_turn (channel 0).
    localparam int TBL [NROW][8] = '{
        '{1,1,0,5,12, 0,0,0},  // R3 wr at high mark, no switch
        '{1,1,0,5,13, 0,0,0},  // R3 above mark, only 2 reads
        '{1,1,0,5,13, 0,1,0},  // R3 third read -> WRITE pending
        '{1,1,0,5,12, 1,1,1},  // R7 turn, R4 1 write < min
        '{1,1,0,5,11, 1,0,0},  // R4 reads pending, 2 writes
        '{1,1,0,4,11, 0,0,1},  // R7 back to READ
        '{1,0,0,0, 6, 0,0,0},  // R2 wr equal low mark, stay
        '{1,0,1,0, 6, 0,1,0},  // R2 drain forces WRITE
        '{1,1,1,0, 5, 1,1,1},  // R4 drain holds WRITE
        '{1,1,1,0, 3, 1,1,0},  // R4 below low but draining
        '{1,1,0,0, 3, 1,0,0},  // R4 below low, no drain -> READ
        '{1,0,0,0, 3, 0,0,1},  // R2 few writes, stay
        '{1,0,0,0, 7, 0,1,0},  // R2 above low -> WRITE
        '{1,1,0,0, 0, 1,0,1},  // R4 write queue empty
        '{1,0,0,2, 0, 0,0,1},  // R7 turn to READ
        '{1,1,0,2,20, 0,0,0},  // R6 read count restarted: 1
        '{1,1,0,2,20, 0,0,0},  // R6 2 reads
        '{1,1,0,2,20, 0,1,0},  // R6 3 reads -> WRITE
        '{1,1,0,2,20, 1,1,1},  // R6 write count restarted: 1
        '{1,1,0,2,20, 1,0,0},  // R6 2 writes -> READ
        '{0,1,0,2,20, 1,0,0},  // R7 no step, hold
        '{1,0,0,2,20, 0,0,1}   // R6 read count 0 after turn
    };

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cur ch0/1", int'(cur_dir), 0);
        chk("R1 nxt ch0/1", int'(nxt_dir), 0);
        chk("R1 turn",      int'(turn),    0);

        for (int i = 0; i < NROW; i++) begin
            step[0]           = TBL[i][0][0];
            burst[0]          = TBL[i][1][0];
            drain             = TBL[i][2][0];
            rd_occ[0 +: OCC_W] = OCC_W'(TBL[i][3]);
            wr_occ[0 +: OCC_W] = OCC_W'(TBL[i][4]);
            step[1]  = 1'b0;
            rd_occ[OCC_W +: OCC_W] = OCC_W'(0);
            wr_occ[OCC_W +: OCC_W] = OCC_W'(15);
            @(negedge clk);
            chk($sformatf("R2-table row %0d cur", i),  int'(cur_dir[0]), TBL[i][5]);
            chk($sformatf("R4-table row %0d nxt", i),  int'(nxt_dir[0]), TBL[i][6]);
            chk($sformatf("R7 row %0d turn", i),       int'(turn[0]),    TBL[i][7]);
            chk($sformatf("R8 row %0d idle ch1", i),   int'({cur_dir[1], nxt_dir[1], turn[1]}), 0);
        end

        // R8: channel 1 alone switches to WRITE while channel 0 stays READ.
        step = 2'b11; burst = 2'b01; drain = 1'b0;
        rd_occ = {OCC_W'(0), OCC_W'(2)};
        wr_occ = {OCC_W'(9), OCC_W'(0)};
        @(negedge clk);
        chk("R8 ch1 nxt WRITE", int'(nxt_dir[1]), 1);
        chk("R8 ch0 nxt READ",  int'(nxt_dir[0]), 0);
        @(negedge clk);
        chk("R8 ch1 cur WRITE", int'(cur_dir[1]), 1);
        chk("R8 ch1 turn",      int'(turn[1]),    1);
        chk("R8 ch0 cur READ",  int'(cur_dir[0]), 0);
        chk("R8 ch0 no turn",   int'(turn[0]),    0);
        step = 2'b00;
        @(negedge clk);
        chk("R7 pulse one cycle", int'(turn), 0);
        chk("R7 ch1 holds WRITE", int'(cur_dir[1]), 1);

        // R1: synchronous reset mid-run returns every channel to READ.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cur after reset", int'(cur_dir), 0);
        chk("R1 nxt after reset", int'(nxt_dir), 0);
        chk("R1 turn after reset", int'(turn), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule